// File: doc/BRIEF.md
# Synchronous Tag Memory with Compare

A small single-port synchronous memory meant to hold cache tags. Each word is 18 bits wide and is split into two 9-bit lanes (eight data bits and a parity bit per lane). Lane 0 is bits 8:0 and lane 1 is bits 17:9. A requester can read a word, write chosen lanes, write the whole word at once, or run a compare. A compare reads the addressed word with the data output held off. It checks that word against the registered input value and reports equality on a match flag.

Requests are sampled on the rising clock edge. A mode input picks the timing for both read data and the match flag. In flow-through mode the result appears after the edge that samples the request. In pipelined mode an output register adds one more cycle. Two enables gate the data and match outputs combinationally. Each output has a drive flag for the pad drivers, and the value reads zero whenever its drive flag is low. A power-down input freezes the memory and releases both outputs. The address comes from outside; any burst sequencing is done by the requester.

Top module: `tag_sram_cmp`

## Requirements
- R1: A read (`sel` high; `gw` low; `bwe` low or `lane_sel` zero; `cmp` low) drives the stored word at `addr` on `dout` with `dout_drv` high.
- R2: With `gw` low, a request with `bwe` high writes lane i only when `lane_sel[i]` is high; lane 0 is bits 8:0 and lane 1 is bits 17:9. The other lanes keep their contents.
- R3: With `gw` high, a request writes every lane, whatever `bwe` and `lane_sel` are.
- R4: The input data register loads `din` only on edges where `data_en` is high. Writes and compares use the registered value, so a write with `data_en` low stores the value held from before.
- R5: A compare (`cmp` high, no lane write) leaves `dout_drv` low. Its match result is high exactly when all 18 bits of the stored word equal the registered input, parity bits 8 and 17 included.
- R6: With `flow_mode` high, read data and the match result are valid in the cycle after the sampling edge. With `flow_mode` low they are valid one cycle later, and `dout_drv` is still low in the first cycle.
- R7: `oe` and `match_oe` gate `dout_drv` and `match_drv` without waiting for a clock edge.
- R8: While `pwr_down` is high, requests are ignored, no write takes place, and `dout_drv` and `match_drv` are low. Stored words are unchanged afterwards.
- R9: The match flag keeps the last compare result until the next compare; it is 0 after reset.
- R10: A compare issued on the edge right after a write to the same address sees the newly written word.
- R11: A lane write takes priority over a compare, and a compare over a read. A request with `bwe` high, `lane_sel` zero and `gw` low is not a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control and output registers |
| pwr_down | input | 1 | Standby: ignore requests, block writes, release outputs |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = pipelined timing |
| sel | input | 1 | Request valid on this edge |
| addr | input | ADDR_W | Word address |
| gw | input | 1 | Write all lanes |
| bwe | input | 1 | Lane-write enable |
| lane_sel | input | NB | Per-lane write strobes |
| cmp | input | 1 | Compare request |
| data_en | input | 1 | Load the input data register |
| din | input | WORD_W | Write or compare data |
| oe | input | 1 | Data output enable (combinational) |
| match_oe | input | 1 | Match output enable (combinational) |
| dout | output | WORD_W | Read data, zero when not driven |
| dout_drv | output | 1 | Data pad drive enable |
| match | output | 1 | Compare result, zero when not driven |
| match_drv | output | 1 | Match pad drive enable |

## Verification
The bench builds the block with its default 6-bit address and two 9-bit lanes. That makes the whole 64-word array small enough to fill first and mirror in a bench model, so random reads, lane writes and compares always have a known expectation. Random traffic stays on the low 16 addresses, which keeps write, read and compare collisions on the same word frequent. Both timing modes are switched between requests, and the parity bits take part in every compare.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2,
      OP_CMP   = 2'd3
   } tag_op_e;
endpackage

// File: rtl/tagram_ctrl.sv
module tagram_ctrl
   import tagram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int WORD_W = 18,
   parameter int NB     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              gw,
   input  logic              bwe,
   input  logic [NB-1:0]     lane_sel,
   input  logic              cmp,
   input  logic              data_en,
   input  logic [WORD_W-1:0] din,
   output tag_op_e           op_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [WORD_W-1:0] din_q,
   output logic [NB-1:0]     wr_mask
);
   logic [NB-1:0] mask_d, mask_q;
   tag_op_e       op_d;

   // decode with priority write > compare > read
   always_comb begin
      mask_d = gw ? {NB{1'b1}} : (bwe ? lane_sel : {NB{1'b0}});
      if (!sel || pwr_down)  op_d = OP_IDLE;
      else if (|mask_d)      op_d = OP_WRITE;
      else if (cmp)          op_d = OP_CMP;
      else                   op_d = OP_READ;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_IDLE;
         addr_q <= '0;
         mask_q <= '0;
         din_q  <= '0;
      end else begin
         op_q   <= op_d;
         mask_q <= (op_d == OP_WRITE) ? mask_d : '0;
         if (op_d != OP_IDLE) addr_q <= addr;
         if (data_en)         din_q  <= din;
      end
   end

   // the second stage commits the write unless standby has begun
   assign wr_mask = (op_q == OP_WRITE && !pwr_down) ? mask_q : '0;

   a_r4_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !data_en |=> $stable(din_q));
   a_r3_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && gw && !pwr_down) |=> (op_q == OP_WRITE && mask_q == {NB{1'b1}}));
   a_r2_lane_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !gw && bwe && !pwr_down) |=> (mask_q == $past(lane_sel)));
   a_r11_cmp_yields: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && cmp && gw && !pwr_down) |=> (op_q == OP_WRITE));
endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NB     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pwr_down,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NB-1:0]        wr_mask,
   input  logic [NB*BYTE_W-1:0] wdata,
   output logic [NB*BYTE_W-1:0] rd_word
);
   localparam int DEPTH = 1 << ADDR_W;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      logic [BYTE_W-1:0] lane_mem [DEPTH];

      always_ff @(posedge clk) begin
         if (wr_mask[b]) lane_mem[addr] <= wdata[b*BYTE_W +: BYTE_W];
      end

      assign rd_word[b*BYTE_W +: BYTE_W] = lane_mem[addr];

      a_r2_lane_lands: assert property (@(posedge clk) disable iff (!rst_n)
         wr_mask[b] |=> (lane_mem[$past(addr)] == $past(wdata[b*BYTE_W +: BYTE_W])));
   end

   a_r8_standby_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> (wr_mask == '0));
endmodule

// File: rtl/tagram_out.sv
module tagram_out
   import tagram_pkg::*;
#(
   parameter int WORD_W = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              flow_mode,
   input  logic              oe,
   input  logic              match_oe,
   input  tag_op_e           op_q,
   input  logic [WORD_W-1:0] rd_word,
   input  logic [WORD_W-1:0] din_q,
   output logic [WORD_W-1:0] dout,
   output logic              dout_drv,
   output logic              match,
   output logic              match_drv
);
   logic              hit;
   logic [WORD_W-1:0] pipe_data;
   logic              pipe_v;
   logic              match_r;
   logic [WORD_W-1:0] data_sel;
   logic              data_ok;
   logic              match_sel;

   assign hit = (rd_word == din_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pipe_data <= '0;
         pipe_v    <= 1'b0;
         match_r   <= 1'b0;
      end else begin
         pipe_v <= (op_q == OP_READ);
         if (op_q == OP_READ) pipe_data <= rd_word;
         if (op_q == OP_CMP)  match_r   <= hit;
      end
   end

   always_comb begin
      if (flow_mode) begin
         data_ok   = (op_q == OP_READ);
         data_sel  = rd_word;
         match_sel = (op_q == OP_CMP) ? hit : match_r;
      end else begin
         data_ok   = pipe_v;
         data_sel  = pipe_data;
         match_sel = match_r;
      end
   end

   assign dout_drv  = oe && !pwr_down && data_ok;
   assign dout      = dout_drv ? data_sel : '0;
   assign match_drv = match_oe && !pwr_down;
   assign match     = match_drv && match_sel;

   a_r6_pipe_stage: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_READ) |=> (pipe_v && pipe_data == $past(rd_word)));
   a_r5_cmp_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q == OP_CMP) |=> !pipe_v);
   a_r9_match_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (op_q != OP_CMP) |=> $stable(match_r));
   a_r8_released: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |-> (!dout_drv && !match_drv && !match));
endmodule

// File: rtl/tag_sram_cmp.sv
module tag_sram_cmp
   import tagram_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int BYTE_W = 9,
   parameter int NB     = 2,
   localparam int WORD_W = BYTE_W * NB
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_down,
   input  logic              flow_mode,
   input  logic              sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic              gw,
   input  logic              bwe,
   input  logic [NB-1:0]     lane_sel,
   input  logic              cmp,
   input  logic              data_en,
   input  logic [WORD_W-1:0] din,
   input  logic              oe,
   input  logic              match_oe,
   output logic [WORD_W-1:0] dout,
   output logic              dout_drv,
   output logic              match,
   output logic              match_drv
);
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr_w
      $error("tag_sram_cmp: ADDR_W must lie in 1..12");
   end
   if (BYTE_W < 2) begin : g_bad_byte_w
      $error("tag_sram_cmp: BYTE_W must be at least 2");
   end
   if (NB < 1 || NB > 8) begin : g_bad_nb
      $error("tag_sram_cmp: NB must lie in 1..8");
   end

   tag_op_e           op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] din_q;
   logic [NB-1:0]     wr_mask;
   logic [WORD_W-1:0] rd_word;

   tagram_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .NB(NB)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .sel(sel), .addr(addr),
      .gw(gw), .bwe(bwe), .lane_sel(lane_sel), .cmp(cmp), .data_en(data_en),
      .din(din), .op_q(op_q), .addr_q(addr_q), .din_q(din_q), .wr_mask(wr_mask)
   );

   tagram_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .NB(NB)) u_array (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .addr(addr_q),
      .wr_mask(wr_mask), .wdata(din_q), .rd_word(rd_word)
   );

   tagram_out #(.WORD_W(WORD_W)) u_out (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .flow_mode(flow_mode),
      .oe(oe), .match_oe(match_oe), .op_q(op_q), .rd_word(rd_word),
      .din_q(din_q), .dout(dout), .dout_drv(dout_drv), .match(match),
      .match_drv(match_drv)
   );

   a_r7_async_gate: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !dout_drv);
   a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (flow_mode && oe && !pwr_down && op_q == OP_READ) |-> (dout_drv && dout == rd_word));
endmodule

// File: tb/tb_tag_sram_cmp.sv
module tb_tag_sram_cmp;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int W  = 18;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwr_down = 1'b0, flow_mode = 1'b1, sel = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          gw = 1'b0, bwe = 1'b0, cmp = 1'b0, data_en = 1'b0;
   logic [1:0]    lane_sel = '0;
   logic [W-1:0]  din = '0;
   logic          oe = 1'b1, match_oe = 1'b1;
   logic [W-1:0]  dout;
   logic          dout_drv, match, match_drv;

   int checks = 0;
   int errors = 0;

   logic [W-1:0] mdl [64];
   logic [W-1:0] mdl_din = '0;
   logic         mdl_match = 1'b0;
   logic [W-1:0] res_q;
   logic         res_v, res_m, early_v;

   always #(CLK_PERIOD/2) clk = ~clk;

   tag_sram_cmp dut (
      .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .flow_mode(flow_mode),
      .sel(sel), .addr(addr), .gw(gw), .bwe(bwe), .lane_sel(lane_sel),
      .cmp(cmp), .data_en(data_en), .din(din), .oe(oe), .match_oe(match_oe),
      .dout(dout), .dout_drv(dout_drv), .match(match), .match_drv(match_drv)
   );

   task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      sel = 0; gw = 0; bwe = 0; lane_sel = '0; cmp = 0; data_en = 0;
   endtask

   function automatic logic [W-1:0] merge(input logic [W-1:0] old,
                                          input logic [W-1:0] nw,
                                          input logic [1:0] m);
      logic [W-1:0] r = old;
      if (m[0]) r[8:0]  = nw[8:0];
      if (m[1]) r[17:9] = nw[17:9];
      return r;
   endfunction

   // kind: 0 read, 1 lane write, 2 global write, 3 compare, 4 lane write with cmp
   task automatic do_op(input int kind, input int a, input logic [W-1:0] d,
                        input bit de, input logic [1:0] bs);
      bit is_wr, is_cmp;
      logic [1:0] m;
      @(negedge clk);
      sel = 1; addr = AW'(a); din = d; data_en = de;
      gw = (kind == 2); bwe = (kind == 1 || kind == 4); lane_sel = bs;
      cmp = (kind == 3 || kind == 4);
      @(negedge clk);
      go_idle();
      early_v = dout_drv;
      if (!flow_mode) @(negedge clk);
      res_q = dout; res_v = dout_drv; res_m = match;
      if (de) mdl_din = d;
      m      = (kind == 2) ? 2'b11 : ((kind == 1 || kind == 4) ? bs : 2'b00);
      is_wr  = (m != 2'b00);
      is_cmp = !is_wr && (kind == 3 || kind == 4);
      if (is_wr) begin
         chk(res_v == 0, "R11 write left dout undriven", {17'd0, res_v}, '0);
         chk(res_m == mdl_match, "R9 match held over write", {17'd0, res_m}, {17'd0, mdl_match});
         mdl[a] = merge(mdl[a], mdl_din, m);
      end else if (is_cmp) begin
         mdl_match = (mdl[a] == mdl_din);
         chk(res_v == 0, "R5 compare keeps dout off", {17'd0, res_v}, '0);
         chk(res_m == mdl_match, "R5 compare result", {17'd0, res_m}, {17'd0, mdl_match});
      end else begin
         chk(res_v == 1 && res_q == mdl[a], "R1 read data", res_q, mdl[a]);
         if (!flow_mode)
            chk(early_v == 0, "R6 pipelined read not early", {17'd0, early_v}, '0);
         chk(res_m == mdl_match, "R9 match held over read", {17'd0, res_m}, {17'd0, mdl_match});
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [W-1:0] v;
      void'($urandom(32'd20517));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(dout_drv == 0, "R6 reset: dout not driven", {17'd0, dout_drv}, '0);
      chk(match == 0 && match_drv == 1, "R9 reset: match low", {17'd0, match}, '0);

      // fill the array so the model is complete
      for (int i = 0; i < 64; i++) do_op(2, i, W'($urandom), 1, 2'b00);

      // R2 lane strobes
      do_op(2, 2, 18'h3FFFF, 1, 2'b00);
      do_op(1, 2, 18'h00000, 1, 2'b01);
      do_op(0, 2, '0, 0, 2'b00);
      chk(res_q == 18'h3FE00, "R2 only lane 0 written", res_q, 18'h3FE00);
      do_op(1, 2, 18'h00000, 1, 2'b10);
      do_op(0, 2, '0, 0, 2'b00);
      chk(res_q == 18'h00000, "R2 lane 1 written", res_q, 18'h00000);

      // R3 global write ignores bwe and strobes
      do_op(2, 4, 18'h2A5A5, 1, 2'b00);
      do_op(0, 4, '0, 0, 2'b00);
      chk(res_q == 18'h2A5A5, "R3 global write", res_q, 18'h2A5A5);

      // R4 write with data_en low keeps held value
      do_op(2, 6, 18'h12345, 1, 2'b00);
      do_op(2, 8, 18'h3FFFF, 0, 2'b00);
      do_op(0, 8, '0, 0, 2'b00);
      chk(res_q == 18'h12345, "R4 held data written", res_q, 18'h12345);

      // R11 bwe with no strobes is a read; write beats compare
      do_op(1, 8, 18'h00001, 0, 2'b00);
      chk(res_v == 1 && res_q == 18'h12345, "R11 empty strobes read", res_q, 18'h12345);
      do_op(4, 8, 18'h00777, 1, 2'b11);
      do_op(0, 8, '0, 0, 2'b00);
      chk(res_q == 18'h00777, "R11 write wins over compare", res_q, 18'h00777);

      // R5 parity bit participates, in both modes
      for (int md = 0; md < 2; md++) begin
         flow_mode = md[0];
         do_op(3, 8, 18'h00777 ^ 18'h20000, 1, 2'b00);
         chk(res_m == 0, "R5 parity-only mismatch", {17'd0, res_m}, '0);
         do_op(3, 8, 18'h00777, 1, 2'b00);
         chk(res_m == 1, "R5 full match", {17'd0, res_m}, 18'd1);
         do_op(3, 8, 18'h00777 ^ 18'h00100, 1, 2'b00);
         chk(res_m == 0, "R5 lane0 parity mismatch", {17'd0, res_m}, '0);
      end

      // R9 hold across idle cycles in pipelined mode
      flow_mode = 0;
      do_op(3, 8, 18'h00777, 1, 2'b00);
      repeat (4) @(negedge clk);
      chk(match == 1, "R9 match held while idle", {17'd0, match}, 18'd1);

      // R10 compare right after write, both modes
      for (int md = 0; md < 2; md++) begin
         flow_mode = md[0];
         v = 18'h1C3C3 + 18'(md);
         @(negedge clk);
         sel = 1; addr = 7; din = v; data_en = 1; gw = 1; bwe = 0; cmp = 0;
         @(negedge clk);
         gw = 0; cmp = 1; data_en = 0;
         @(negedge clk);
         go_idle();
         if (md == 0) @(negedge clk);
         chk(match == 1, "R10 compare sees new word", {17'd0, match}, 18'd1);
         chk(dout_drv == 0, "R10 compare keeps dout off", {17'd0, dout_drv}, '0);
         mdl[7] = v; mdl_din = v; mdl_match = 1;
         repeat (2) @(negedge clk);
      end

      // R7 asynchronous enables on a held pipelined read
      flow_mode = 0;
      @(negedge clk);
      sel = 1; addr = 4; bwe = 0; gw = 0; cmp = 0; data_en = 0;
      @(negedge clk); go_idle();
      @(negedge clk);
      oe = 0; #1;
      chk(dout_drv == 0 && dout == '0, "R7 oe off releases dout", {17'd0, dout_drv}, '0);
      oe = 1; #1;
      chk(dout_drv == 1 && dout == mdl[4], "R7 oe on drives dout", dout, mdl[4]);
      match_oe = 0; #1;
      chk(match_drv == 0, "R7 match_oe off", {17'd0, match_drv}, '0);
      match_oe = 1; #1;
      chk(match_drv == 1, "R7 match_oe on", {17'd0, match_drv}, 18'd1);

      // R8 standby
      @(negedge clk);
      pwr_down = 1;
      sel = 1; addr = 5; din = 18'h3ABCD; data_en = 0; gw = 1;
      #1;
      chk(dout_drv == 0 && match_drv == 0, "R8 outputs released", {17'd0, match_drv}, '0);
      repeat (3) @(negedge clk);
      go_idle();
      pwr_down = 0;
      flow_mode = 1;
      do_op(0, 5, '0, 0, 2'b00);
      chk(res_q == mdl[5], "R8 contents kept", res_q, mdl[5]);

      // constrained random traffic on a narrow address window
      for (int n = 0; n < 400; n++) begin
         int k;
         logic [1:0] bs;
         logic [W-1:0] d;
         flow_mode = $urandom_range(1, 0) == 1;
         k  = int'($urandom_range(4, 0));
         bs = 2'($urandom_range(3, 0));
         d  = (($urandom_range(3, 0) == 0) ? mdl[n % 16] : W'($urandom));
         do_op(k, int'($urandom_range(15, 0)), d, $urandom_range(7, 0) != 0, bs);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule